// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register Port

This block is the byte-wide host side of a two-channel serial controller. The host sees four byte locations, which are a control port and a data port for each of two channels. Two address bits pick the channel and the port. A `bit_swap` input exchanges which bit does which job. Each channel holds sixteen configuration (write) registers and presents a set of status (read) registers. Control-port access is indirect. The host first writes a register pointer and then accesses the selected register. After every access the pointer falls back to register 0. Register 0 also carries one-shot commands. Register 9 carries reset commands that restore one channel, the other channel, or both to their power-up contents.

The rest of the controller reads all thirty-two configuration bytes from `cfg_bank`. It also gets a baud divisor per channel and one-cycle strobes for data written, data read, channel reset, clear transmit interrupt and reset highest-under-service. Received bytes arrive on `rx_data` with an `rx_arrive` strobe. Channel index 0 is channel B and index 1 is channel A. In `cfg_bank`, register r of channel c occupies bits [(c*16+r)*8 +: 8]. The serial shifters, line drivers and DMA lie outside this block.

The power-up write-register contents are: register 4 = 0x04, register 9 = 0xC0, register 11 = 0x08, register 14 = 0x30, register 15 = 0xF8, and all other write registers 0.

Top module: `ptr_serial_regport`

## Requirements
- R1: After hardware reset, both channels hold the power-up write-register contents. Read register 0 reads 0x44 and read register 1 reads 0x07. Every other read register reads 0, `rdata` is 0 and all strobes are low.
- R2: A control write while the pointer is 0 loads wdata[2:0] as the pointer. A control read returns the selected read register, and the pointer then returns to 0, so the next control read returns read register 0.
- R3: A pointer-0 control write whose command field wdata[5:3] is 001 adds 8 to the pointer, which reaches registers 8 to 15.
- R4: A control write while the pointer is nonzero stores the byte in the selected write register and returns the pointer to 0.
- R5: Read registers 12 and 13 return the current contents of write registers 12 and 13.
- R6: Writing register 9 with bits [7:6] = 01 resets channel B, with 10 resets channel A, and with 11 resets both. A reset restores the R1 contents of the reset channels, is not stored itself, and pulses `chan_reset_pulse` for those channels for one cycle. With bits [7:6] = 00 the byte is stored and nothing resets.
- R7: With `bit_swap` = 0, addr[0] selects the port (0 control, 1 data) and addr[1] selects the channel. With `bit_swap` = 1 the two roles are exchanged.
- R8: The baud divisor of each channel is ({reg13, reg12} + 2) multiplied by 1, 16, 32 or 64 for register 4 bits [7:6] = 00, 01, 10, 11.
- R9: A data write pulses `data_wr_pulse` and sets read register 0 bit 2 and read register 1 bit 0. An `rx_arrive` strobe sets read register 0 bit 0. A data read returns the channel's `rx_data` byte, clears read register 0 bit 0 and pulses `data_rd_pulse`.
- R10: A pointer-0 control write with command field 101 pulses `clr_tx_pulse`, and one with command field 111 pulses `ius_reset_pulse`, each for one cycle and for the addressed channel.
- R11: `rdata` is registered. It is valid the cycle after a read strobe and holds otherwise. When `wr_en` and `rd_en` are high together, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bit_swap | input | 1 | Exchanges the port and channel address bits |
| addr | input | 2 | Port and channel select |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | DATA_W | Write byte |
| rdata | output | DATA_W | Registered read byte |
| rx_data | input | 2*DATA_W | Received byte per channel |
| rx_arrive | input | 2 | Received-byte strobe per channel |
| data_wr_pulse | output | 2 | Data port written |
| data_rd_pulse | output | 2 | Data port read |
| clr_tx_pulse | output | 2 | Clear-transmit-interrupt command |
| ius_reset_pulse | output | 2 | Reset-highest-under-service command |
| chan_reset_pulse | output | 2 | Channel reset by command |
| cfg_bank | output | 32*DATA_W | All write registers of both channels |
| baud_div | output | 2*(2*DATA_W+7) | Baud divisor per channel |

## Verification
The pointer protocol is swept over all sixteen register indices on both channels. Each indexed read is followed by a bare control read, which shows whether the pointer actually fell back to 0. The port/channel swap is checked by writing under one swap setting and reading under the other with distinct values per channel. A transposed decode therefore cannot pass. The divisor is swept across all four prescale codes and four time constants, including 0 and 0xFFFF, with the other channel compared each time to catch cross-talk. The reset codes 01, 10, 11 and 00 are applied from the opposite channel and from the same channel, and each is checked against the whole configuration bank.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int unsigned NUM_CH  = 2;
   localparam int unsigned REG_CNT = 16;
   localparam int unsigned PTR_W   = $clog2(REG_CNT);

   localparam int unsigned IDX_MODE = 4;
   localparam int unsigned IDX_RST  = 9;
   localparam int unsigned IDX_TCLO = 12;
   localparam int unsigned IDX_TCHI = 13;

   localparam logic [7:0] ST0_INIT = 8'h44;
   localparam logic [7:0] ST1_INIT = 8'h07;

   typedef enum logic [2:0] {
      CMD_NONE   = 3'b000,
      CMD_UPPER  = 3'b001,
      CMD_CLR_TX = 3'b101,
      CMD_IUS    = 3'b111
   } cmd_e;

   function automatic logic [7:0] cfg_init(input int unsigned idx);
      case (idx)
         4:       return 8'h04;
         9:       return 8'hC0;
         11:      return 8'h08;
         14:      return 8'h30;
         15:      return 8'hF8;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/regport_decode.sv
module regport_decode #(
   parameter int PORT_BIT = 0
) (
   input  logic [1:0] addr,
   input  logic       bit_swap,
   output logic       is_data,
   output logic       chan
);
   localparam int CHAN_BIT = 1 - PORT_BIT;

   generate
      if (PORT_BIT != 0 && PORT_BIT != 1) begin : g_bad
         $error("PORT_BIT must be 0 or 1");
      end
   endgenerate

   always_comb begin
      if (bit_swap) begin
         is_data = addr[CHAN_BIT];
         chan    = addr[PORT_BIT];
      end else begin
         is_data = addr[PORT_BIT];
         chan    = addr[CHAN_BIT];
      end
   end
endmodule

// File: rtl/regport_baud.sv
module regport_baud #(
   parameter int TC_W  = 16,
   parameter int DIV_W = TC_W + 7
) (
   input  logic [TC_W-1:0]  tc,
   input  logic [1:0]       scale,
   output logic [DIV_W-1:0] div
);
   logic [DIV_W-1:0] base;

   generate
      if (DIV_W < TC_W + 7) begin : g_bad
         $error("DIV_W too narrow for a x64 prescale");
      end
   endgenerate

   assign base = DIV_W'(tc) + DIV_W'(2);

   always_comb begin
      case (scale)
         2'd0:    div = base;
         2'd1:    div = base << 4;
         2'd2:    div = base << 5;
         default: div = base << 6;
      endcase
   end
endmodule

// File: rtl/regport_chan.sv
module regport_chan
   import sreg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      soft_rst,
   input  logic                      ctl_wr,
   input  logic                      ctl_rd,
   input  logic                      dat_wr,
   input  logic                      dat_rd,
   input  logic                      rx_arrive,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rd_val,
   output logic [NUM_CH-1:0]         rst_req,
   output logic [REG_CNT*DATA_W-1:0] bank,
   output logic                      wr_pulse,
   output logic                      rd_pulse,
   output logic                      clr_pulse,
   output logic                      ius_pulse
);
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] wreg [REG_CNT];
   logic [DATA_W-1:0] st0, st1;
   cmd_e              cmd;
   logic              at_rst_reg;

   assign cmd        = cmd_e'(wdata[5:3]);
   assign at_rst_reg = (ptr == PTR_W'(IDX_RST));
   assign rst_req    = (ctl_wr && at_rst_reg) ? {wdata[7], wdata[6]} : '0;

   generate
      for (genvar r = 0; r < REG_CNT; r++) begin : g_bank
         assign bank[r*DATA_W +: DATA_W] = wreg[r];
      end
   endgenerate

   always_comb begin
      case (ptr)
         PTR_W'(0):        rd_val = st0;
         PTR_W'(1):        rd_val = st1;
         PTR_W'(IDX_TCLO): rd_val = wreg[IDX_TCLO];
         PTR_W'(IDX_TCHI): rd_val = wreg[IDX_TCHI];
         default:          rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < REG_CNT; r++) wreg[r] <= DATA_W'(cfg_init(r));
         ptr       <= '0;
         st0       <= DATA_W'(ST0_INIT);
         st1       <= DATA_W'(ST1_INIT);
         wr_pulse  <= 1'b0;
         rd_pulse  <= 1'b0;
         clr_pulse <= 1'b0;
         ius_pulse <= 1'b0;
      end else if (soft_rst) begin
         for (int r = 0; r < REG_CNT; r++) wreg[r] <= DATA_W'(cfg_init(r));
         ptr       <= '0;
         st0       <= DATA_W'(ST0_INIT);
         st1       <= DATA_W'(ST1_INIT);
         wr_pulse  <= 1'b0;
         rd_pulse  <= 1'b0;
         clr_pulse <= 1'b0;
         ius_pulse <= 1'b0;
      end else begin
         wr_pulse  <= dat_wr;
         rd_pulse  <= dat_rd;
         clr_pulse <= ctl_wr && (ptr == '0) && (cmd == CMD_CLR_TX);
         ius_pulse <= ctl_wr && (ptr == '0) && (cmd == CMD_IUS);
         if (ctl_wr) begin
            if (ptr == '0) begin
               ptr <= {cmd == CMD_UPPER, wdata[2:0]};
            end else begin
               if (!(at_rst_reg && wdata[7:6] != 2'b00)) wreg[ptr] <= wdata;
               ptr <= '0;
            end
         end
         if (ctl_rd) ptr <= '0;
         if (dat_wr) begin
            st0[2] <= 1'b1;
            st1[0] <= 1'b1;
         end
         if (dat_rd)    st0[0] <= 1'b0;
         if (rx_arrive) st0[0] <= 1'b1;
      end
   end
endmodule

// File: rtl/ptr_serial_regport.sv
module ptr_serial_regport
   import sreg_pkg::*;
#(
   parameter int  DATA_W   = 8,
   parameter int  PORT_BIT = 0,
   localparam int TC_W     = 2 * DATA_W,
   localparam int DIV_W    = TC_W + 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             bit_swap,
   input  logic [1:0]                       addr,
   input  logic                             wr_en,
   input  logic                             rd_en,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   input  logic [NUM_CH*DATA_W-1:0]         rx_data,
   input  logic [NUM_CH-1:0]                rx_arrive,
   output logic [NUM_CH-1:0]                data_wr_pulse,
   output logic [NUM_CH-1:0]                data_rd_pulse,
   output logic [NUM_CH-1:0]                clr_tx_pulse,
   output logic [NUM_CH-1:0]                ius_reset_pulse,
   output logic [NUM_CH-1:0]                chan_reset_pulse,
   output logic [NUM_CH*REG_CNT*DATA_W-1:0] cfg_bank,
   output logic [NUM_CH*DIV_W-1:0]          baud_div
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic              is_data, chan;
   logic              rd_ok;
   logic [NUM_CH-1:0] soft_rst;
   logic [NUM_CH-1:0] rst_req [NUM_CH];
   logic [DATA_W-1:0] rd_val  [NUM_CH];

   regport_decode #(.PORT_BIT(PORT_BIT)) u_dec (
      .addr(addr), .bit_swap(bit_swap), .is_data(is_data), .chan(chan)
   );

   assign rd_ok    = rd_en && !wr_en;
   assign soft_rst = rst_req[0] | rst_req[1];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic sel;
         assign sel = (chan == c[0]);

         regport_chan #(.DATA_W(DATA_W)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst[c]),
            .ctl_wr   (wr_en && sel && !is_data),
            .ctl_rd   (rd_ok && sel && !is_data),
            .dat_wr   (wr_en && sel && is_data),
            .dat_rd   (rd_ok && sel && is_data),
            .rx_arrive(rx_arrive[c]),
            .wdata    (wdata),
            .rd_val   (rd_val[c]),
            .rst_req  (rst_req[c]),
            .bank     (cfg_bank[c*REG_CNT*DATA_W +: REG_CNT*DATA_W]),
            .wr_pulse (data_wr_pulse[c]),
            .rd_pulse (data_rd_pulse[c]),
            .clr_pulse(clr_tx_pulse[c]),
            .ius_pulse(ius_reset_pulse[c])
         );

         regport_baud #(.TC_W(TC_W), .DIV_W(DIV_W)) u_baud (
            .tc   ({cfg_bank[(c*REG_CNT+IDX_TCHI)*DATA_W +: DATA_W],
                    cfg_bank[(c*REG_CNT+IDX_TCLO)*DATA_W +: DATA_W]}),
            .scale(cfg_bank[(c*REG_CNT+IDX_MODE)*DATA_W + 6 +: 2]),
            .div  (baud_div[c*DIV_W +: DIV_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata            <= '0;
         chan_reset_pulse <= '0;
      end else begin
         chan_reset_pulse <= soft_rst;
         if (rd_ok) rdata <= is_data ? rx_data[chan*DATA_W +: DATA_W] : rd_val[chan];
      end
   end
endmodule

// File: rtl/regport_chk.sv
module regport_chk
   import sreg_pkg::*;
#(
   parameter int  DATA_W   = 8,
   parameter int  PORT_BIT = 0,
   localparam int DIV_W    = 2 * DATA_W + 7
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             bit_swap,
   input logic [1:0]                       addr,
   input logic                             wr_en,
   input logic                             rd_en,
   input logic [DATA_W-1:0]                wdata,
   input logic [DATA_W-1:0]                rdata,
   input logic [NUM_CH*DATA_W-1:0]         rx_data,
   input logic [NUM_CH-1:0]                data_wr_pulse,
   input logic [NUM_CH-1:0]                data_rd_pulse,
   input logic [NUM_CH-1:0]                clr_tx_pulse,
   input logic [NUM_CH-1:0]                ius_reset_pulse,
   input logic [NUM_CH-1:0]                chan_reset_pulse,
   input logic [NUM_CH*DIV_W-1:0]          baud_div
);
   logic              port_bit, ch_bit;
   logic [DATA_W-1:0] rx_sel;

   assign port_bit = bit_swap ? addr[1-PORT_BIT] : addr[PORT_BIT];
   assign ch_bit   = bit_swap ? addr[PORT_BIT]   : addr[1-PORT_BIT];
   assign rx_sel   = ch_bit ? rx_data[DATA_W +: DATA_W] : rx_data[0 +: DATA_W];

   assert_one_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({data_wr_pulse, data_rd_pulse, clr_tx_pulse, ius_reset_pulse}));

   assert_data_wr_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_bit) |=> (data_wr_pulse != '0));

   assert_data_rd_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && port_bit) |=> (rdata == $past(rx_sel)));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || wr_en) |=> $stable(rdata));

   assert_reset_from_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_reset_pulse != '0) |-> $past(wr_en && !port_bit));

   assert_clr_from_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tx_pulse != '0) |-> $past(wr_en && !port_bit && wdata[5:3] == 3'b101));

   assert_baud_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(baud_div));
endmodule

bind ptr_serial_regport regport_chk #(.DATA_W(DATA_W), .PORT_BIT(PORT_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_swap(bit_swap), .addr(addr),
   .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
   .rx_data(rx_data), .data_wr_pulse(data_wr_pulse),
   .data_rd_pulse(data_rd_pulse), .clr_tx_pulse(clr_tx_pulse),
   .ius_reset_pulse(ius_reset_pulse), .chan_reset_pulse(chan_reset_pulse),
   .baud_div(baud_div)
);

// File: tb/sim_ptr_serial_regport.sv
module sim_ptr_serial_regport;
   localparam int DW = 8;
   localparam int VW = 2 * DW + 7;

   logic           clk = 1'b0;
   logic           rst_n, bit_swap, wr_en, rd_en;
   logic [1:0]     addr;
   logic [DW-1:0]  wdata, rdata;
   logic [2*DW-1:0] rx_data;
   logic [1:0]     rx_arrive;
   logic [1:0]     data_wr_pulse, data_rd_pulse, clr_tx_pulse, ius_reset_pulse, chan_reset_pulse;
   logic [2*16*DW-1:0] cfg_bank;
   logic [2*VW-1:0] baud_div;

   always #5 clk = ~clk;

   ptr_serial_regport u0 (
      .clk(clk), .rst_n(rst_n), .bit_swap(bit_swap), .addr(addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .rx_data(rx_data), .rx_arrive(rx_arrive),
      .data_wr_pulse(data_wr_pulse), .data_rd_pulse(data_rd_pulse),
      .clr_tx_pulse(clr_tx_pulse), .ius_reset_pulse(ius_reset_pulse),
      .chan_reset_pulse(chan_reset_pulse), .cfg_bank(cfg_bank), .baud_div(baud_div)
   );

   int n_chk = 0, n_bad = 0;
   logic [7:0] wr_m [2][16];
   logic       rxav_m [2];
   logic [1:0] s_wrp, s_rdp, s_clr, s_ius, s_rst;
   logic [7:0] v;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] init_val(input int r);
      case (r)
         4: return 8'h04;  9: return 8'hC0;  11: return 8'h08;
         14: return 8'h30; 15: return 8'hF8; default: return 8'h00;
      endcase
   endfunction

   task automatic model_reset(input int ch);
      for (int r = 0; r < 16; r++) wr_m[ch][r] = init_val(r);
      rxav_m[ch] = 1'b0;
   endtask

   function automatic logic [7:0] exp_rr(input int ch, input int idx);
      case (idx)
         0: return 8'h44 | {7'd0, rxav_m[ch]};
         1: return 8'h07;
         12: return wr_m[ch][12];
         13: return wr_m[ch][13];
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [31:0] exp_div(input int ch);
      int tc = {wr_m[ch][13], wr_m[ch][12]} + 2;
      int sh;
      case (wr_m[ch][4][7:6])
         2'd0: sh = 0; 2'd1: sh = 4; 2'd2: sh = 5; default: sh = 6;
      endcase
      return 32'(tc << sh);
   endfunction

   function automatic logic [1:0] adr(input int ch, input bit port);
      return bit_swap ? {port, ch[0]} : {ch[0], port};
   endfunction

   task automatic op(input bit we, input bit re, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = we; rd_en = re; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      s_wrp = data_wr_pulse; s_rdp = data_rd_pulse; s_clr = clr_tx_pulse;
      s_ius = ius_reset_pulse; s_rst = chan_reset_pulse;
   endtask

   task automatic ctl_wr(input int ch, input logic [7:0] d); op(1, 0, adr(ch, 0), d); endtask
   task automatic ctl_rd(input int ch); op(0, 1, adr(ch, 0), 8'h00); endtask

   task automatic set_ptr(input int ch, input int idx);
      if (idx >= 8) ctl_wr(ch, 8'h08 | 8'(idx & 7));
      else if (idx != 0) ctl_wr(ch, 8'(idx));
   endtask

   task automatic write_reg(input int ch, input int idx, input logic [7:0] d);
      set_ptr(ch, idx);
      ctl_wr(ch, d);
      if (idx == 9 && d[7:6] != 2'b00) begin
         if (d[6]) model_reset(0);
         if (d[7]) model_reset(1);
      end else wr_m[ch][idx] = d;
   endtask

   task automatic read_reg(input int ch, input int idx, output logic [7:0] r);
      set_ptr(ch, idx);
      ctl_rd(ch);
      r = rdata;
   endtask

   task automatic check_bank(input string tag);
      for (int c = 0; c < 2; c++) begin
         for (int r = 0; r < 16; r++)
            check(tag, 32'(cfg_bank[(c*16+r)*8 +: 8]), 32'(wr_m[c][r]));
         check(tag, 32'(baud_div[c*VW +: VW]), exp_div(c));
      end
   endtask

   task automatic rx_push(input int ch, input logic [7:0] b);
      @(negedge clk);
      rx_data[ch*8 +: 8] = b; rx_arrive[ch] = 1'b1;
      @(negedge clk);
      rx_arrive = 2'b00;
      rxav_m[ch] = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] tcs [4];
      tcs[0] = 16'h0000; tcs[1] = 16'h0001; tcs[2] = 16'h1234; tcs[3] = 16'hFFFF;
      rst_n = 1'b0; bit_swap = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 2'b00;
      wdata = '0; rx_data = '0; rx_arrive = 2'b00;
      model_reset(0); model_reset(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state at the ports
      check_bank("R1 bank");
      check("R1 rdata", 32'(rdata), 32'h0);
      check("R1 strobes", 32'({data_wr_pulse, data_rd_pulse, clr_tx_pulse, ius_reset_pulse, chan_reset_pulse}), 32'h0);

      // R2 / R3: full pointer sweep, each followed by a bare read (pointer back at 0)
      for (int ch = 0; ch < 2; ch++)
         for (int idx = 0; idx < 16; idx++) begin
            read_reg(ch, idx, v);
            check(idx >= 8 ? "R3 upper read" : "R2 lower read", 32'(v), 32'(exp_rr(ch, idx)));
            ctl_rd(ch);
            check("R2 pointer cleared after read", 32'(rdata), 32'(exp_rr(ch, 0)));
         end

      // R7: write under swap, read back without swap
      bit_swap = 1'b1;
      write_reg(1, 12, 8'h3C);
      write_reg(0, 13, 8'h5D);
      read_reg(0, 13, v);
      check("R7 swapped read", 32'(v), 32'h5D);
      bit_swap = 1'b0;
      read_reg(1, 12, v); check("R7 ch1 reg12", 32'(v), 32'h3C);
      read_reg(0, 12, v); check("R7 ch0 reg12", 32'(v), 32'h00);
      read_reg(0, 13, v); check("R7 ch0 reg13", 32'(v), 32'h5D);
      check_bank("R7 bank");

      // R8 / R5: divisor sweep over prescale and time constant
      for (int ch = 0; ch < 2; ch++)
         for (int ps = 0; ps < 4; ps++)
            for (int t = 0; t < 4; t++) begin
               write_reg(ch, 12, tcs[t][7:0]);
               write_reg(ch, 13, tcs[t][15:8]);
               write_reg(ch, 4, 8'(ps << 6) | 8'h04);
               check("R8 divisor", 32'(baud_div[ch*VW +: VW]), exp_div(ch));
               check("R8 other channel", 32'(baud_div[(1-ch)*VW +: VW]), exp_div(1 - ch));
               if (ps == 0) begin
                  read_reg(ch, 12, v); check("R5 mirror lo", 32'(v), 32'(tcs[t][7:0]));
                  read_reg(ch, 13, v); check("R5 mirror hi", 32'(v), 32'(tcs[t][15:8]));
               end
            end

      // R4: write to nonzero pointer stores and clears the pointer
      write_reg(0, 5, 8'hAA);
      ctl_rd(0);
      check("R4 pointer cleared after write", 32'(rdata), 32'(exp_rr(0, 0)));
      check_bank("R4 bank");

      // R6: reset codes
      write_reg(1, 9, 8'h40);
      check("R6 code01 pulse", 32'(s_rst), 32'h1);
      check_bank("R6 code01 bank");
      ctl_rd(1);
      check("R6 writer pointer cleared", 32'(rdata), 32'(exp_rr(1, 0)));
      write_reg(0, 12, 8'h21);
      write_reg(0, 9, 8'h80);
      check("R6 code10 pulse", 32'(s_rst), 32'h2);
      check_bank("R6 code10 bank");
      write_reg(0, 9, 8'h15);
      check("R6 code00 no pulse", 32'(s_rst), 32'h0);
      check_bank("R6 code00 stored");
      write_reg(1, 12, 8'h11);
      write_reg(1, 9, 8'hC0);
      check("R6 code11 pulse", 32'(s_rst), 32'h3);
      check_bank("R6 code11 bank");

      // R10: one-shot commands
      ctl_wr(1, 8'h28);
      check("R10 clr tx", 32'({s_clr, s_ius}), 32'({2'b10, 2'b00}));
      ctl_wr(0, 8'h38);
      check("R10 ius reset", 32'({s_clr, s_ius}), 32'({2'b00, 2'b01}));
      ctl_wr(0, 8'h2B);
      check("R10 clr with pointer", 32'(s_clr), 32'h1);
      ctl_rd(0);
      check("R10 R2 pointer 3 read", 32'(rdata), 32'h0);

      // R9: receive and transmit data path
      rx_push(0, 8'h5A);
      read_reg(0, 0, v); check("R9 rx available set", 32'(v), 32'h45);
      op(0, 1, adr(0, 1), 8'h00);
      rxav_m[0] = 1'b0;
      check("R9 data read byte", 32'(rdata), 32'h5A);
      check("R9 data read pulse", 32'(s_rdp), 32'h1);
      read_reg(0, 0, v); check("R9 rx available cleared", 32'(v), 32'h44);
      op(1, 0, adr(1, 1), 8'h77);
      check("R9 data write pulse", 32'(s_wrp), 32'h2);
      read_reg(1, 0, v); check("R9 tx empty", 32'(v), 32'h44);
      read_reg(1, 1, v); check("R9 all sent", 32'(v), 32'h07);

      // R11: hold and write-over-read priority
      rx_push(1, 8'hC3);
      op(0, 1, adr(1, 1), 8'h00);
      rxav_m[1] = 1'b0;
      check("R11 read valid next cycle", 32'(rdata), 32'hC3);
      repeat (3) @(negedge clk);
      check("R11 rdata holds", 32'(rdata), 32'hC3);
      op(1, 1, adr(0, 0), 8'h01);
      check("R11 read ignored under write", 32'(rdata), 32'hC3);
      ctl_rd(0);
      check("R11 write performed", 32'(rdata), 32'h07);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule